// File: doc/BRIEF.md
# One-Bit Accumulator Instruction Executor

This block runs one instruction at a time on a tiny 1-bit machine. The machine holds two 1-bit general registers and a 1-bit accumulator. A 6-bit instruction word is driven on input pins, and a one-cycle execute pulse starts it. The block captures the word, decodes it, and performs either a move or a bitwise logic step. It then commits the result to the destination after a latency that depends on which storage element is written.

A ready output tells the surrounding logic when the next pulse will be taken. All three state bits are driven out for observation. Program storage, sequencing and branching belong to whatever feeds the instruction pins.

Top module: `onebit_exec`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears both general registers and the accumulator to 0 and leaves `ready_o` high.
- R2: The instruction word is split as bits [5:4] register address, bit [3] immediate bit, bits [2:0] opcode. Address 00 names general register 0, 01 names general register 1, and both 10 and 11 name the accumulator.
- R3: Opcode 000 stores the immediate bit into the addressed register.
- R4: Opcode 001 copies the accumulator into the addressed register. When the address names the accumulator, the accumulator keeps its value.
- R5: Opcodes 010, 011 and 101 replace the accumulator with the OR, XOR and AND respectively of the accumulator and the addressed register. When the address names the accumulator, the operand is the accumulator's own value.
- R6: Opcode 100 inverts the accumulator whatever the address and immediate bits hold.
- R7: Opcodes 110 and 111 change no state and complete one cycle after acceptance.
- R8: A pulse taken while `ready_o` is high drops `ready_o` in the next cycle. `ready_o` rises again, with the result visible, exactly L cycles after the accepting edge, where L is 3 when register 0 is written, 2 for register 1, and 1 for the accumulator or a no-op.
- R9: An execute pulse that arrives while `ready_o` is low is ignored and does not lengthen the operation.
- R10: The instruction is captured when it is accepted. Changes on `instr_i` after that point do not affect the running operation.
- R11: While an operation is pending, no state bit changes. At completion, only the destination may change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_i | input | 1 | One-cycle execute pulse |
| instr_i | input | 6 | Instruction word: address, immediate, opcode |
| ready_o | output | 1 | High when idle and able to accept a pulse |
| reg0_o | output | 1 | General register 0 |
| reg1_o | output | 1 | General register 1 |
| acc_o | output | 1 | Accumulator |

## Verification
Every one of the 64 instruction words is applied from each of the 8 combinations of the three state bits. This distinguishes each opcode's truth table, the aliasing of addresses 10 and 11, and the self-operand cases on the accumulator. It also separates the three write latencies cycle by cycle.

During each pending operation, the bench inverts the instruction pins and pulses execute. A design that re-samples the pins or re-arms on a busy pulse then produces the wrong result or the wrong completion cycle. A reset in the middle of a slow register write checks that the pending write is discarded.

// File: rtl/onebit_pkg.sv
// Shared types and helpers for the one-bit executor.
// Assumes a fixed 6-bit word: address[5:4], immediate[3], opcode[2:0].
package onebit_pkg;

    localparam int WORD_W = 6;
    localparam int NSTATE = 3;   // reg0, reg1, accumulator

    typedef enum logic [2:0] {
        OP_LDI  = 3'b000,
        OP_CPA  = 3'b001,
        OP_OR   = 3'b010,
        OP_XOR  = 3'b011,
        OP_INV  = 3'b100,
        OP_AND  = 3'b101,
        OP_NOPA = 3'b110,
        OP_NOPB = 3'b111
    } op_e;

    typedef struct packed {
        logic [1:0] sel;
        logic       imm;
        op_e        op;
    } word_t;

    // One-hot destination index positions
    localparam int IDX_R0  = 0;
    localparam int IDX_R1  = 1;
    localparam int IDX_ACC = 2;

    // Destination one-hot for a word; zero for no-ops
    function automatic logic [NSTATE-1:0] dest_of(word_t w);
        logic [NSTATE-1:0] d;
        d = '0;
        unique case (w.op)
            OP_LDI, OP_CPA: begin
                if (w.sel == 2'b00)      d[IDX_R0]  = 1'b1;
                else if (w.sel == 2'b01) d[IDX_R1]  = 1'b1;
                else                     d[IDX_ACC] = 1'b1;
            end
            OP_OR, OP_XOR, OP_AND, OP_INV: d[IDX_ACC] = 1'b1;
            default: d = '0;
        endcase
        return d;
    endfunction

    // Cycles from acceptance to commit, given per-destination latencies
    function automatic int latency_of(word_t w, int l0, int l1, int la, int ln);
        logic [NSTATE-1:0] d;
        d = dest_of(w);
        if (d[IDX_R0])       return l0;
        else if (d[IDX_R1])  return l1;
        else if (d[IDX_ACC]) return la;
        return ln;
    endfunction

endpackage

// File: rtl/onebit_decode.sv
// Combinational decode and ALU for a captured instruction word.
// Produces the one-hot destination and the value to be written.
// Assumes state inputs are stable while the word is pending.
module onebit_decode
    import onebit_pkg::*;
(
    input  word_t             word_i,
    input  logic [NSTATE-1:0] state_i,
    output logic [NSTATE-1:0] dest_o,
    output logic              val_o
);

    logic opnd;
    logic accv;

    // Select the operand named by the address field
    always_comb begin
        accv = state_i[IDX_ACC];
        unique case (word_i.sel)
            2'b00:   opnd = state_i[IDX_R0];
            2'b01:   opnd = state_i[IDX_R1];
            default: opnd = accv;
        endcase
    end

    // Compute the result bit for each opcode
    always_comb begin
        unique case (word_i.op)
            OP_LDI:  val_o = word_i.imm;
            OP_CPA:  val_o = accv;
            OP_OR:   val_o = accv | opnd;
            OP_XOR:  val_o = accv ^ opnd;
            OP_AND:  val_o = accv & opnd;
            OP_INV:  val_o = ~accv;
            default: val_o = 1'b0;
        endcase
    end

    // Destination selection
    always_comb dest_o = dest_of(word_i);

endmodule

// File: rtl/onebit_sequencer.sv
// Countdown sequencer: accepts a pulse when idle, loads the latency,
// and raises a commit strobe in the last pending cycle.
// Assumes every latency is at least 1 and at most LAT_MAX.
module onebit_sequencer #(
    parameter int LAT_MAX = 3,
    localparam int CNT_W  = $clog2(LAT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  logic [CNT_W-1:0] lat_i,
    output logic             ready_o,
    output logic             accept_o,
    output logic             fire_o
);

    logic [CNT_W-1:0] cnt;

    // Idle, accept and commit decode from the counter
    always_comb begin
        ready_o  = (cnt == '0);
        accept_o = ready_o && exec_i;
        fire_o   = (cnt == CNT_W'(1));
    end

    // Load on accept, count down while pending
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (accept_o) cnt <= lat_i;
        else if (!ready_o) cnt <= cnt - 1'b1;
    end

    p_accept_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !ready_o);

    p_busy_pulse_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> (cnt == $past(cnt) - 1'b1));

    p_fire_then_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> ready_o);

endmodule

// File: rtl/onebit_regfile.sv
// Three 1-bit storage elements written by a one-hot destination strobe.
// Assumes at most one destination bit is set per write.
module onebit_regfile
    import onebit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [NSTATE-1:0] dest_i,
    input  logic              val_i,
    output logic [NSTATE-1:0] state_o
);

    for (genvar g = 0; g < NSTATE; g++) begin : g_bit
        // Clear on reset, update when this bit is the destination
        always_ff @(posedge clk) begin
            if (!rst_n)                      state_o[g] <= 1'b0;
            else if (wr_en_i && dest_i[g])   state_o[g] <= val_i;
        end
    end

    p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(state_o));

    p_single_dest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> $onehot0(dest_i));

endmodule

// File: rtl/onebit_exec.sv
// Top: one-bit accumulator instruction executor. Captures the word on an
// accepted pulse, waits a destination-dependent latency, then commits.
// Assumes the caller only pulses exec_i for one cycle per instruction.
module onebit_exec
    import onebit_pkg::*;
#(
    parameter int LAT_R0  = 3,
    parameter int LAT_R1  = 2,
    parameter int LAT_ACC = 1,
    parameter int LAT_NOP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [WORD_W-1:0] instr_i,
    output logic              ready_o,
    output logic              reg0_o,
    output logic              reg1_o,
    output logic              acc_o
);

    localparam int LAT_A   = (LAT_R0 > LAT_R1) ? LAT_R0 : LAT_R1;
    localparam int LAT_B   = (LAT_ACC > LAT_NOP) ? LAT_ACC : LAT_NOP;
    localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    word_t             pin_word;
    word_t             word_q;
    logic [CNT_W-1:0]  lat_load;
    logic              accept;
    logic              fire;
    logic [NSTATE-1:0] state;
    logic [NSTATE-1:0] dest;
    logic              wval;

    // Latency of the word on the pins, used at acceptance
    always_comb begin
        pin_word = word_t'(instr_i);
        lat_load = CNT_W'(latency_of(pin_word, LAT_R0, LAT_R1, LAT_ACC, LAT_NOP));
    end

    // Capture the instruction word when accepted
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '{sel: 2'b00, imm: 1'b0, op: OP_NOPA};
        else if (accept) word_q <= pin_word;
    end

    onebit_sequencer #(.LAT_MAX(LAT_MAX)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_i   (exec_i),
        .lat_i    (lat_load),
        .ready_o  (ready_o),
        .accept_o (accept),
        .fire_o   (fire)
    );

    onebit_decode u_dec (
        .word_i  (word_q),
        .state_i (state),
        .dest_o  (dest),
        .val_o   (wval)
    );

    onebit_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (fire),
        .dest_i  (dest),
        .val_i   (wval),
        .state_o (state)
    );

    // Drive observation outputs
    always_comb begin
        reg0_o = state[IDX_R0];
        reg1_o = state[IDX_R1];
        acc_o  = state[IDX_ACC];
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (ready_o && !reg0_o && !reg1_o && !acc_o));

    p_accept_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && exec_i) |=> $stable({reg0_o, reg1_o, acc_o}));

    p_invert_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && word_q.op == OP_INV) |=> (acc_o == !$past(acc_o)));

    p_nop_no_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (word_q.op == OP_NOPA || word_q.op == OP_NOPB))
            |=> $stable({reg0_o, reg1_o, acc_o}));

endmodule

// File: tb/sim_onebit_exec.sv
`timescale 1ns/1ps
module sim_onebit_exec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_i = 1'b0;
    logic [5:0] instr_i = 6'd0;
    logic       ready_o, reg0_o, reg1_o, acc_o;

    int checks = 0;
    int failures = 0;

    // Bench model state
    logic m0, m1, ma;

    always #2.5 clk = ~clk;

    onebit_exec u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_i  (exec_i),
        .instr_i (instr_i),
        .ready_o (ready_o),
        .reg0_o  (reg0_o),
        .reg1_o  (reg1_o),
        .acc_o   (acc_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_state(input string tag);
        check({reg0_o, reg1_o, acc_o} == {m0, m1, ma}, tag,
              {reg0_o, reg1_o, acc_o}, {m0, m1, ma});
    endtask

    // Run one instruction against the arithmetic model (R2 field layout)
    task automatic run(input logic [5:0] w);
        logic [1:0] sel;
        logic       z, opnd;
        logic [2:0] op;
        logic       n0, n1, na;
        int         lat;
        string      tag;
        sel = w[5:4]; z = w[3]; op = w[2:0];
        opnd = (sel == 2'd0) ? m0 : (sel == 2'd1) ? m1 : ma;
        n0 = m0; n1 = m1; na = ma; lat = 1;
        case (op)
            3'd0: begin tag = "R3/R2/R10";
                  if (sel == 0) begin n0 = z; lat = 3; end
                  else if (sel == 1) begin n1 = z; lat = 2; end
                  else na = z; end
            3'd1: begin tag = "R4/R2/R10";
                  if (sel == 0) begin n0 = ma; lat = 3; end
                  else if (sel == 1) begin n1 = ma; lat = 2; end end
            3'd2: begin tag = "R5/R10"; na = ma | opnd; end
            3'd3: begin tag = "R5/R10"; na = ma ^ opnd; end
            3'd5: begin tag = "R5/R10"; na = ma & opnd; end
            3'd4: begin tag = "R6/R10"; na = ~ma; end
            default: tag = "R7/R10";
        endcase
        exec_i = 1'b1; instr_i = w;
        @(negedge clk);
        for (int i = 1; i <= lat; i++) begin
            check(ready_o == 1'b0, "R8", ready_o, 0);
            check_state("R11");
            // Busy pulse with altered pins must have no effect (R9, R10)
            exec_i = 1'b1; instr_i = ~w;
            @(negedge clk);
        end
        exec_i = 1'b0;
        m0 = n0; m1 = n1; ma = na;
        check(ready_o == 1'b1, "R8/R9", ready_o, 1);
        check_state(tag);
    endtask

    initial begin
        m0 = 0; m1 = 0; ma = 0;
        repeat (3) @(negedge clk);
        check(ready_o == 1'b1, "R1", ready_o, 1);
        check_state("R1");
        rst_n = 1'b1;
        @(negedge clk);
        // Exhaustive sweep: all start states by all words
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 64; w++) begin
                run({2'b00, s[2], 3'b000});
                run({2'b01, s[1], 3'b000});
                run({2'b10, s[0], 3'b000});
                run(w[5:0]);
            end
        end
        // Reset during a slow write discards it (R1)
        run({2'b00, 1'b1, 3'b000});
        run({2'b10, 1'b1, 3'b000});
        exec_i = 1'b1; instr_i = {2'b01, 1'b1, 3'b000};
        @(negedge clk);
        exec_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        m0 = 0; m1 = 0; ma = 0;
        check(ready_o == 1'b1, "R1", ready_o, 1);
        check_state("R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_state("R1");
        // Idle pins changing without a pulse do nothing (R10)
        instr_i = 6'b111100;
        repeat (2) @(negedge clk);
        check_state("R10");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule